// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital half of a successive approximation analog-to-digital converter. A one-cycle start strobe opens a conversion. The block then drives a trial code to an external DAC and reads back one comparator bit. That bit is high when the sampled input lies below the DAC level for the current trial. Each clock settles one bit of the code, beginning at the most significant bit and ending at the least significant. After the last bit, the block presents the final code and raises a single-cycle completion pulse.

The sample-and-hold, the DAC and the comparator sit outside the block. The sequencer relies only on the comparator answering combinationally for the trial code it currently drives. The trial code is registered, so the DAC sees a stable value for a whole clock period. The result stays on its port until the next accepted start. A synchronous active-low reset returns everything to idle with all outputs at zero.

Top module: `sar_conv_ctrl`

## Requirements
- R1: One clock edge after a start strobe is accepted in idle, the trial code holds only its most significant bit set and every other bit at 0.
- R2: On each busy edge, the bit under test is cleared when the comparator input is 1 (input below DAC level). It stays 1 when the comparator input is 0.
- R3: On each busy edge other than the last, the next lower bit is set to 1 as the new trial, and bits above it keep their decided values.
- R4: A WIDTH-bit conversion takes exactly WIDTH busy edges after the start edge. The done output is high for exactly one cycle, following the edge that decides bit 0.
- R5: When done is high, the trial code equals the result, and the trial code keeps that value while idle.
- R6: A start strobe seen while a conversion is busy has no effect: the conversion runs to its end with an unchanged result and timing, and no new conversion begins.
- R7: The result changes only on the edge that raises done, and it is held through idle cycles and ignored strobes until the next conversion completes.
- R8: A clock edge with reset low sets trial, result and done to 0 and returns the block to idle, including in the middle of a conversion.
- R9: With WIDTH = 5, a 1 V reference and a 0.6 V input, the result is binary 10011.
- R10: A start strobe given in the cycle done is high is accepted, so a new conversion can follow with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only when idle |
| cmp_below_i | input | 1 | Comparator result, 1 when the input is below the DAC level |
| trial_o | output | WIDTH | Registered trial code driven to the DAC |
| result_o | output | WIDTH | Final conversion code, held between conversions |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Every cycle, the assertions check several properties. They check that reset clears the outputs and that an accepted start loads the MSB-only trial. They check that the tested bit follows the comparator and that a busy strobe never restarts the bit pointer. They also check that done is a single pulse matching the trial code and that the result never moves except on done. Other properties need the bench's scenarios, because they depend on a modelled comparator and a known input. These are the exact trial sequence across a conversion, the final code for a given input, the WIDTH-cycle latency, the back-to-back restart and the 5-bit reference case.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } sar_phase_e;
endpackage

// File: rtl/sar_ptr_step.sv
// Walks the one-hot bit pointer one place toward the LSB.
module sar_ptr_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] ptr_i,
    output logic [WIDTH-1:0] ptr_next_o,
    output logic             last_o
);
    assign ptr_next_o = {1'b0, ptr_i[WIDTH-1:1]};
    assign last_o     = ptr_i[0];
endmodule

// File: rtl/sar_decide.sv
// Resolves the bit under test and forms the next trial code.
module sar_decide #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] trial_i,
    input  logic [WIDTH-1:0] ptr_i,
    input  logic [WIDTH-1:0] ptr_next_i,
    input  logic             below_i,
    output logic [WIDTH-1:0] decided_o,
    output logic [WIDTH-1:0] next_trial_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign decided_o[i]    = ptr_i[i] ? ~below_i : trial_i[i];
        assign next_trial_o[i] = decided_o[i] | ptr_next_i[i];
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_below_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);
    import sar_pkg::*;

    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        sar_phase_e       phase;
        logic [WIDTH-1:0] ptr;
        logic [WIDTH-1:0] trial;
        logic [WIDTH-1:0] result;
        logic             done;
    } sar_state_t;

    sar_state_t st_d, st_q;

    logic [WIDTH-1:0] ptr_next;
    logic             ptr_last;
    logic [WIDTH-1:0] decided;
    logic [WIDTH-1:0] next_trial;

    sar_ptr_step #(.WIDTH(WIDTH)) u_step (
        .ptr_i      (st_q.ptr),
        .ptr_next_o (ptr_next),
        .last_o     (ptr_last)
    );

    sar_decide #(.WIDTH(WIDTH)) u_decide (
        .trial_i      (st_q.trial),
        .ptr_i        (st_q.ptr),
        .ptr_next_i   (ptr_next),
        .below_i      (cmp_below_i),
        .decided_o    (decided),
        .next_trial_o (next_trial)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase = PH_RUN;
                st_d.ptr   = MSB_ONLY;
                st_d.trial = MSB_ONLY;
            end
        end else if (ptr_last) begin
            st_d.phase  = PH_IDLE;
            st_d.ptr    = '0;
            st_d.trial  = decided;
            st_d.result = decided;
            st_d.done   = 1'b1;
        end else begin
            st_d.ptr   = ptr_next;
            st_d.trial = next_trial;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ptr: '0, trial: '0, result: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic             busy_q;
    logic [WIDTH-1:0] ptr_q;
    assign busy_q   = (st_q.phase == PH_RUN);
    assign ptr_q    = st_q.ptr;
    assign trial_o  = st_q.trial;
    assign result_o = st_q.result;
    assign done_o   = st_q.done;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmp_below_i,
    input logic [WIDTH-1:0] trial_o,
    input logic [WIDTH-1:0] result_o,
    input logic             done_o,
    input logic             busy,
    input logic [WIDTH-1:0] ptr
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (trial_o == '0 && result_o == '0 && !done_o));

    // R1
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (trial_o == MSB_ONLY));

    // R2
    bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp_below_i) |=> ((trial_o & $past(ptr)) == '0));

    // R2
    bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_below_i) |=> ((trial_o & $past(ptr)) != '0));

    // R6
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> (ptr != MSB_ONLY));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (trial_o == result_o));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && $past(rst_n)) |-> $stable(result_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_below_i (cmp_below_i),
    .trial_o     (trial_o),
    .result_o    (result_o),
    .done_o      (done_o),
    .busy        (busy_q),
    .ptr         (ptr_q)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] vin = '0;
    logic cmp;
    logic [N-1:0] trial, result;
    logic done;

    logic start5 = 1'b0;
    logic cmp5;
    logic [4:0] trial5, result5;
    logic done5;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Ideal comparator: input below the DAC level for the current trial
    assign cmp  = (vin < trial);
    // 5-bit case: 0.6 V against a 1 V reference, scaled to millivolts * 32
    assign cmp5 = (32'd19200 < ({27'd0, trial5} * 32'd1000));

    sar_conv_ctrl #(.WIDTH(N)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_below_i(cmp),
        .trial_o(trial), .result_o(result), .done_o(done)
    );

    sar_conv_ctrl #(.WIDTH(5)) dut5 (
        .clk(clk), .rst_n(rst_n), .start_i(start5), .cmp_below_i(cmp5),
        .trial_o(trial5), .result_o(result5), .done_o(done5)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int search_ref(input int v);
        int code = 0;
        for (int i = N - 1; i >= 0; i--) begin
            code = code | (1 << i);
            if (v < code) code = code & ~(1 << i);
        end
        return code;
    endfunction

    // Expected trial after busy edge k (1..N-1)
    function automatic int partial_ref(input int v, input int k);
        int mask = ((1 << N) - 1) & ~((1 << (N - k)) - 1);
        return (v & mask) | (1 << (N - 1 - k));
    endfunction

    task automatic begin_conv(input int v);
        vin = v[N-1:0];
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Entered just after the start edge; leaves just after the done edge.
    // poke: 1 = strobe mid-run, 2 = strobe on the deciding edge of bit 0
    task automatic finish_conv(input int v, input int poke, input int prev_result);
        int exp = search_ref(v);
        chk(trial == (1 << (N - 1)), "R1 MSB-only trial", int'(trial), 1 << (N - 1));
        for (int k = 1; k < N; k++) begin
            if (poke == 1 && k == 3) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk(trial == partial_ref(v, k), "R2/R3 trial step", int'(trial), partial_ref(v, k));
            chk(!done, "R4 done early", int'(done), 0);
            chk(result == prev_result, "R7 result held while busy", int'(result), prev_result);
        end
        if (poke == 2) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done, "R4 done after N cycles", int'(done), 1);
        chk(result == exp, "R4 final code", int'(result), exp);
        chk(trial == result, "R5 trial equals result", int'(trial), int'(result));
    endtask

    task automatic idle_after(input int v);
        int exp = search_ref(v);
        @(negedge clk);
        chk(!done, "R4 done one cycle", int'(done), 0);
        chk(result == exp, "R7 result held", int'(result), exp);
        chk(trial == exp, "R6/R5 no restart, trial held", int'(trial), exp);
    endtask

    initial begin
        int last_res = 0;
        int v;
        int v2;
        int p;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(trial == 0 && result == 0 && !done, "R8 reset state", int'(trial) + int'(result), 0);
        rst_n = 1'b1;

        // Directed corners
        begin_conv(0);   finish_conv(0, 0, last_res);   idle_after(0);   last_res = 0;
        begin_conv(255); finish_conv(255, 0, last_res); idle_after(255); last_res = 255;
        begin_conv(128); finish_conv(128, 2, last_res); idle_after(128); last_res = 128;
        begin_conv(77);  finish_conv(77, 1, last_res);  idle_after(77);  last_res = 77;

        // R10: start in the done cycle
        begin_conv(200); finish_conv(200, 0, last_res); last_res = 200;
        vin = 8'd31;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(trial == (1 << (N - 1)) && !done, "R10 back-to-back accepted", int'(trial), 1 << (N - 1));
        finish_conv(31, 0, last_res); idle_after(31); last_res = 31;

        // R8: reset in mid conversion
        begin_conv(99);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(trial == 0, "R8 mid-run reset trial", int'(trial), 0);
        chk(result == 0, "R8 mid-run reset result", int'(result), 0);
        chk(!done, "R8 mid-run reset done", int'(done), 0);
        rst_n = 1'b1;
        last_res = 0;
        @(negedge clk);
        chk(trial == 0 && !done, "R8 stays idle", int'(trial), 0);

        // Random conversions
        for (int i = 0; i < 60; i++) begin
            v = int'($urandom % 256);
            p = int'($urandom % 3);
            begin_conv(v); finish_conv(v, p, last_res); idle_after(v);
            last_res = search_ref(v);
        end
        v2 = int'($urandom % 256);
        begin_conv(v2); finish_conv(v2, 0, last_res);

        // R9: 5-bit reference case
        @(negedge clk) start5 = 1'b1;
        @(negedge clk) start5 = 1'b0;
        repeat (5) @(negedge clk);
        chk(done5, "R9 done", int'(done5), 1);
        chk(result5 == 5'b10011, "R9 code 10011", int'(result5), 19);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule